// File: doc/BRIEF.md
# Scenario-Based Bank Gating Mask

This block sits beside the banked local memory of a fixed-function accelerator. At the start of each run, software writes the accelerator's configuration fields and then signals that configuration is complete. At that point the block compares the image-size field with a set of ascending scenario limits fixed at design time. It picks the execution scenario and produces one gating bit per SRAM bank.

A bank whose bit is 1 is held fully powered down for the whole run, with both its periphery and its cell array gated. A bank whose bit is 0 stays under the control of the dynamic operating-mode logic. The mask and the scenario index are captured once per run. They stay frozen until the next configuration strobe or a reset.

When the size exceeds every scenario limit, the block falls back to a default scenario. That scenario assumes the whole memory is in use, so it gates no bank. The limits, the bank count and the per-scenario masks are all parameters.

Top module: `gm_bank_gate`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe yet, `gate_mask_o` is all zeros and `scen_o` equals NUM_SCEN (the default index, 2 with default parameters).
- R2: A strobe with an image size of 1024 or less selects scenario 0. In that scenario the mask is 2'b10: bit i controls bank i, bank 0 is left to dynamic control and bank 1 is forced off.
- R3: A strobe with a size from 1025 to 65536 selects scenario 1, whose mask is 2'b00.
- R4: A strobe with a size above 65536 matches no scenario. It selects the default index 2 and gives mask 2'b00, so no bank is forced off.
- R5: The outputs reflect the size present at the clock edge that samples the strobe, and they change at that edge and at no other.
- R6: A change of the size input with no strobe has no effect on either output.
- R7: Strobes on consecutive cycles each take effect. The last one decides the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_done_i | input | 1 | One-cycle strobe marking that the run configuration is written |
| img_size_i | input | SIZE_W (20) | Image-size configuration field |
| gate_mask_o | output | NUM_BANKS (2) | Per-bank forced power-gate mask, 1 = bank off |
| scen_o | output | SCEN_W (2) | Decoded scenario index, NUM_SCEN = default |

## Verification
The capture of a new configuration and a change of the size field can land in the same cycle. The bench provokes this by changing the size on the very cycle the strobe is raised. It also changes the size again on the cycle right after the strobe, and it holds the strobe across two cycles with different sizes. It then judges that the frozen mask and index match the size present at the sampling edge. Random sizes drawn around both limits, including 1024, 1025, 65536 and 65537, are checked against a bench model of the scenario rule.

// File: rtl/gm_pkg.sv
package gm_pkg;
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gm_scen_decode.sv
module gm_scen_decode #(
  parameter int SIZE_W   = 20,
  parameter int NUM_SCEN = 2,
  parameter int SCEN_W   = 2,
  parameter logic [NUM_SCEN-1:0][SIZE_W-1:0] LIMIT = '0
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [SCEN_W-1:0] scen_o
);
  logic [NUM_SCEN-1:0] hit;

  for (genvar k = 0; k < NUM_SCEN; k++) begin : g_cmp
    assign hit[k] = (size_i <= LIMIT[k]);
  end

  // lowest matching scenario wins; no match -> default index NUM_SCEN
  always_comb begin
    scen_o = SCEN_W'(NUM_SCEN);
    for (int k = NUM_SCEN - 1; k >= 0; k--) begin
      if (hit[k]) scen_o = SCEN_W'(k);
    end
  end
endmodule

// File: rtl/gm_mask_table.sv
module gm_mask_table #(
  parameter int NUM_SCEN  = 2,
  parameter int NUM_BANKS = 2,
  parameter int SCEN_W    = 2,
  parameter logic [NUM_SCEN-1:0][NUM_BANKS-1:0] MASK = '0
) (
  input  logic [SCEN_W-1:0]    scen_i,
  output logic [NUM_BANKS-1:0] mask_o
);
  // default scenario keeps every bank available
  always_comb begin
    mask_o = '0;
    for (int k = 0; k < NUM_SCEN; k++) begin
      if (scen_i == SCEN_W'(k)) mask_o = MASK[k];
    end
  end
endmodule

// File: rtl/gm_hold_reg.sv
module gm_hold_reg #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/gm_bank_gate.sv
module gm_bank_gate #(
  parameter int SIZE_W    = 20,
  parameter int NUM_SCEN  = 2,
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_SCEN-1:0][SIZE_W-1:0]    SCEN_LIMIT = {20'd65536, 20'd1024},
  parameter logic [NUM_SCEN-1:0][NUM_BANKS-1:0] SCEN_MASK  = {2'b00, 2'b10},
  localparam int SCEN_W = gm_pkg::idx_w(NUM_SCEN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_done_i,
  input  logic [SIZE_W-1:0]    img_size_i,
  output logic [NUM_BANKS-1:0] gate_mask_o,
  output logic [SCEN_W-1:0]    scen_o
);
  logic [SCEN_W-1:0]    scen_d;
  logic [NUM_BANKS-1:0] mask_d;

  gm_scen_decode #(
    .SIZE_W(SIZE_W), .NUM_SCEN(NUM_SCEN), .SCEN_W(SCEN_W), .LIMIT(SCEN_LIMIT)
  ) u_decode (
    .size_i(img_size_i),
    .scen_o(scen_d)
  );

  gm_mask_table #(
    .NUM_SCEN(NUM_SCEN), .NUM_BANKS(NUM_BANKS), .SCEN_W(SCEN_W), .MASK(SCEN_MASK)
  ) u_table (
    .scen_i(scen_d),
    .mask_o(mask_d)
  );

  gm_hold_reg #(.W(NUM_BANKS), .RST_VAL('0)) u_mask_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_done_i), .d_i(mask_d), .q_o(gate_mask_o)
  );

  gm_hold_reg #(.W(SCEN_W), .RST_VAL(SCEN_W'(NUM_SCEN))) u_scen_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_done_i), .d_i(scen_d), .q_o(scen_o)
  );
endmodule

// File: rtl/gm_bank_gate_chk.sv
module gm_bank_gate_chk #(
  parameter int SIZE_W    = 20,
  parameter int NUM_SCEN  = 2,
  parameter int NUM_BANKS = 2,
  parameter int SCEN_W    = 2,
  parameter logic [NUM_SCEN-1:0][SIZE_W-1:0] SCEN_LIMIT = '0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_done_i,
  input logic [SIZE_W-1:0]    img_size_i,
  input logic [NUM_BANKS-1:0] gate_mask_o,
  input logic [SCEN_W-1:0]    scen_o
);
  AST_SCEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scen_o <= SCEN_W'(NUM_SCEN)); // R1

  AST_FIRST_SCEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_i && (img_size_i <= SCEN_LIMIT[0]) |=> scen_o == '0); // R2

  AST_DEFAULT_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_i && (img_size_i > SCEN_LIMIT[NUM_SCEN-1]) |=> scen_o == SCEN_W'(NUM_SCEN)); // R4

  AST_DEFAULT_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scen_o == SCEN_W'(NUM_SCEN) |-> gate_mask_o == '0); // R4

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |=> $stable(gate_mask_o) && $stable(scen_o)); // R6
endmodule

bind gm_bank_gate gm_bank_gate_chk #(
  .SIZE_W(SIZE_W), .NUM_SCEN(NUM_SCEN), .NUM_BANKS(NUM_BANKS), .SCEN_W(SCEN_W),
  .SCEN_LIMIT(SCEN_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i), .img_size_i(img_size_i),
  .gate_mask_o(gate_mask_o), .scen_o(scen_o)
);

// File: tb/gm_bank_gate_bench.sv
module gm_bank_gate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_done_i = 1'b0;
  logic [19:0] img_size_i = '0;
  logic [1:0]  gate_mask_o;
  logic [1:0]  scen_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  gm_bank_gate u_gm_bank_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i), .img_size_i(img_size_i),
    .gate_mask_o(gate_mask_o), .scen_o(scen_o)
  );

  function automatic logic [1:0] exp_scen(input logic [19:0] s);
    if (s <= 20'd1024)  return 2'd0;
    if (s <= 20'd65536) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] exp_mask(input logic [1:0] sc);
    return (sc == 2'd0) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] es, input logic [1:0] em);
    n_chk++;
    if (scen_o !== es || gate_mask_o !== em) begin
      n_bad++;
      $display("FAIL %s: scen=%0d mask=%b expected scen=%0d mask=%b",
               req, scen_o, gate_mask_o, es, em);
    end
  endtask

  // strobe with a size set in the same cycle, check after the capturing edge
  task automatic apply(input string req, input logic [19:0] s);
    @(negedge clk_i);
    img_size_i = s;
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
    check(req, exp_scen(s), exp_mask(exp_scen(s)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [19:0] s;
    logic [1:0]  hs, hm;
    void'($urandom(32'd1234));
    img_size_i = 20'd500;
    #35;
    check("R1 in reset", 2'd2, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 after reset", 2'd2, 2'b00);

    apply("R2 size 1024", 20'd1024);
    apply("R2 size 0", 20'd0);
    apply("R3 size 1025", 20'd1025);
    apply("R3 size 65536", 20'd65536);
    apply("R4 size 65537", 20'd65537);
    apply("R4 size max", 20'hFFFFF);
    apply("R2 size 1", 20'd1);

    // R6: size moves without strobe, outputs stay
    img_size_i = 20'd70000;
    repeat (3) @(negedge clk_i);
    check("R6 no strobe large", 2'd0, 2'b10);
    img_size_i = 20'd2000;
    @(negedge clk_i);
    check("R6 no strobe mid", 2'd0, 2'b10);

    // R5: size changes on the cycle right after the strobe
    @(negedge clk_i);
    img_size_i = 20'd3000;
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
    img_size_i = 20'd10;
    @(negedge clk_i);
    check("R5 post-strobe change", 2'd1, 2'b00);

    // R7: back-to-back strobes
    @(negedge clk_i);
    img_size_i = 20'd100;
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    check("R7 first strobe", 2'd0, 2'b10);
    img_size_i = 20'd90000;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
    check("R7 second strobe", 2'd2, 2'b00);
    repeat (2) @(negedge clk_i);
    check("R7 held", 2'd2, 2'b00);

    // mid-run reset returns to default
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid reset", 2'd2, 2'b00);
    rst_ni = 1'b1;

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: s = 20'($urandom % 1025);
        1: s = 20'd1025 + 20'($urandom % 64512);
        2: s = 20'd65537 + 20'($urandom % 983038);
        default: s = 20'd1022 + 20'($urandom % 5);
      endcase
      if ($urandom % 3 == 0) begin
        hs = scen_o;
        hm = gate_mask_o;
        @(negedge clk_i);
        img_size_i = s;
        @(negedge clk_i);
        check("R6 random hold", hs, hm);
      end else begin
        apply("R5 random", s);
      end
    end
    finish_run();
  end
endmodule